// File: doc/BRIEF.md
# Oscillator Stabilisation Wait Sequencer

This block keeps the core out of action after a system reset or a stop request until the oscillator has had time to settle. It does this by driving two 8-bit down-counters as one chain. The low counter divides the selected tick stream by 256. Each wrap of the low counter steps the high counter once, and the high counter divides by 8. The wait ends when the high counter overflows. Both counters are loaded with fixed values on every entry: 0xFF into the low stage and 0x07 into the high stage.

The two entry paths choose their tick source differently. After reset, the low stage always counts the main-clock/16 tick, and the software source bits are ignored. After a stop request, the block first waits idle for a wake event. It then counts whichever tick the software source bits select. Software that wants the clock/16 source on this path must set those bits to 00 before it issues the stop. While either wait is running, the core clock enable is held low. When the high counter overflows, the enable rises and the core runs.

Top module: `osw_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until release, `int_rst`=1, `stop_hold`=0 and `core_clk_en`=0.
- R2: During the reset wait only `tick_main16` is counted, whatever `src_sel` holds. Pulses on `tick_sub` and `tick_pin` have no effect.
- R3: The reset wait ends on exactly the 2048th counted tick (256 × 8). After 2047 ticks `int_rst` is still 1. In the cycle after the 2048th tick, `int_rst` is 0.
- R4: Once released, the outputs read `int_rst`=0, `stop_hold`=0 and `core_clk_en`=1.
- R5: A `stop_req` pulse while running gives `stop_hold`=1 and `core_clk_en`=0 in the next cycle. Ticks on any source are not counted until `wake` is pulsed.
- R6: After `wake`, the stop wait counts the source that `src_sel` picks: 00 = `tick_main16`, 01 = `tick_sub`, 10 or 11 = `tick_pin`. The other sources have no effect.
- R7: The stop wait ends on exactly the 2048th selected tick. The block then returns to the running state of R4.
- R8: Asserting `rst_n` during any wait restarts the full 2048-tick reset wait with fresh preload values.
- R9: `core_clk_en` is never 1 while `int_rst` or `stop_hold` is 1, and `int_rst` and `stop_hold` are never 1 together.
- R10: A `stop_req` during the reset wait is ignored. After release the block is running with `stop_hold`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| stop_req | input | 1 | One-cycle request to enter the stop state |
| wake | input | 1 | One-cycle wake event that starts the stop countdown |
| src_sel | input | 2 | Software tick source bits for the low stage (stop path only) |
| tick_main16 | input | 1 | Main clock divided by 16, one-cycle pulse |
| tick_sub | input | 1 | Sub-clock tick, one-cycle pulse |
| tick_pin | input | 1 | External pin tick, one-cycle pulse |
| int_rst | output | 1 | Internal reset held during the reset wait |
| stop_hold | output | 1 | Stop state held (idle or counting) |
| core_clk_en | output | 1 | Clock enable to the core |

## Verification
A wrong preload value or a broken chain link moves the release edge. The bench counts ticks to the exact one, so a release after 2047 or 2049 ticks shows up at that tick. A source mux that honours `src_sel` during reset, or that picks the wrong stream on the stop path, lets foreign pulses advance the count. The release then comes early, on the first boundary check of that case. A state register that leaves the idle stop phase without `wake`, or one that ignores a new reset, shows up within one cycle in the three outputs, or at the next release count.

// File: rtl/osw_pkg.sv
// Package: shared state encoding and tick source codes for the
// oscillator stabilisation wait sequencer.
package osw_pkg;
    typedef enum logic [1:0] {
        ST_RST_WAIT  = 2'd0,
        ST_RUN       = 2'd1,
        ST_STOP_IDLE = 2'd2,
        ST_STOP_WAIT = 2'd3
    } osw_state_e;

    localparam logic [1:0] SRC_MAIN16 = 2'b00;
    localparam logic [1:0] SRC_SUB    = 2'b01;
endpackage

// File: rtl/osw_tick_sel.sv
// Module: picks the tick stream that feeds the low countdown stage.
// Assumes every tick input is a one-cycle pulse in the clk domain.
// When force_main is set, the main/16 tick is used whatever sel holds.
module osw_tick_sel
    import osw_pkg::*;
(
    input  logic       force_main,
    input  logic [1:0] sel,
    input  logic       tick_main16,
    input  logic       tick_sub,
    input  logic       tick_pin,
    output logic       tick
);
    // Source multiplexer, with the forced path taking priority.
    always_comb begin
        if (force_main || sel == SRC_MAIN16) begin
            tick = tick_main16;
        end else if (sel == SRC_SUB) begin
            tick = tick_sub;
        end else begin
            tick = tick_pin;
        end
    end
endmodule

// File: rtl/osw_down_timer.sv
// Module: one down-counting stage with a fixed preload value.
// It reloads on reset or on load. When enabled it decrements, and when
// enabled at zero it raises ovf for that cycle and wraps to the preload.
// Assumes load and cnt_en never need to act in the same cycle
// (load wins if they do).
module osw_down_timer #(
    parameter int          W       = 8,
    parameter logic [W-1:0] PRELOAD = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cnt_en,
    output logic ovf
);
    logic [W-1:0] cnt_q;

    // Overflow fires on the counted step taken from zero.
    assign ovf = cnt_en && (cnt_q == '0);

    // Counter register: preload on reset or load, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= PRELOAD;
        end else if (cnt_en) begin
            cnt_q <= (cnt_q == '0) ? PRELOAD : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/osw_seq.sv
// Module: top of the oscillator stabilisation wait sequencer.
// It chains NSTAGE down-counters and holds the core in reset or stop
// until the last stage overflows. The reset wait forces the main/16
// source. The stop wait uses src_sel and begins only after a wake pulse.
// Assumes synchronous active-low reset and pulse-shaped tick inputs.
module osw_seq
    import osw_pkg::*;
#(
    parameter int             CNT_W  = 8,
    parameter logic [CNT_W-1:0] PRE_LO = 8'hFF,
    parameter logic [CNT_W-1:0] PRE_HI = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake,
    input  logic [1:0] src_sel,
    input  logic       tick_main16,
    input  logic       tick_sub,
    input  logic       tick_pin,
    output logic       int_rst,
    output logic       stop_hold,
    output logic       core_clk_en
);
    localparam int NSTAGE = 2;
    localparam logic [CNT_W-1:0] PRE_TAB [NSTAGE] = '{PRE_LO, PRE_HI};

    osw_state_e         state_q, state_d;
    logic               sel_tick;
    logic               counting;
    logic               reload;
    logic [NSTAGE:0]    stage_en;
    logic [NSTAGE-1:0]  stage_ovf;
    logic               chain_ovf;

    // Source mux: forced to main/16 only while in the reset wait.
    osw_tick_sel u_sel (
        .force_main  (state_q == ST_RST_WAIT),
        .sel         (src_sel),
        .tick_main16 (tick_main16),
        .tick_sub    (tick_sub),
        .tick_pin    (tick_pin),
        .tick        (sel_tick)
    );

    assign counting    = (state_q == ST_RST_WAIT) || (state_q == ST_STOP_WAIT);
    assign reload      = (state_q == ST_RUN) && stop_req;
    assign stage_en[0] = counting && sel_tick;

    // Countdown chain: each stage is stepped by the overflow of the one below.
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        osw_down_timer #(
            .W       (CNT_W),
            .PRELOAD (PRE_TAB[i])
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (reload),
            .cnt_en (stage_en[i]),
            .ovf    (stage_ovf[i])
        );
        assign stage_en[i+1] = stage_ovf[i];
    end

    assign chain_ovf = stage_en[NSTAGE];

    // Next-state logic for the wait sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_WAIT:  if (chain_ovf) state_d = ST_RUN;
            ST_RUN:       if (stop_req)  state_d = ST_STOP_IDLE;
            ST_STOP_IDLE: if (wake)      state_d = ST_STOP_WAIT;
            ST_STOP_WAIT: if (chain_ovf) state_d = ST_RUN;
            default:                     state_d = ST_RST_WAIT;
        endcase
    end

    // State register, with reset restarting the reset wait.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RST_WAIT;
        else        state_q <= state_d;
    end

    // Output decode from the state register.
    always_comb begin
        int_rst     = (state_q == ST_RST_WAIT);
        stop_hold   = (state_q == ST_STOP_IDLE) || (state_q == ST_STOP_WAIT);
        core_clk_en = (state_q == ST_RUN);
    end
endmodule

// File: rtl/osw_seq_chk.sv
// Checker: port-level properties of osw_seq, attached through bind.
// It keeps its own count of main/16 ticks seen during the reset wait.
module osw_seq_chk #(
    parameter int TOTAL = 2048
) (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       wake,
    input logic [1:0] src_sel,
    input logic       tick_main16,
    input logic       tick_sub,
    input logic       tick_pin,
    input logic       int_rst,
    input logic       stop_hold,
    input logic       core_clk_en
);
    logic [15:0] rst_ticks_q;

    // Count the main/16 ticks seen while the reset wait is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rst_ticks_q <= '0;
        else if (int_rst && tick_main16)   rst_ticks_q <= rst_ticks_q + 1'b1;
    end

    // R1: a reset cycle leaves the block in the reset wait.
    p_reset_wait_r1: assert property (@(posedge clk)
        !rst_n |=> (int_rst && !stop_hold && !core_clk_en));

    // R3: the reset wait ends only after exactly TOTAL main/16 ticks.
    p_wait_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst) |-> (rst_ticks_q == TOTAL[15:0]));

    // R5: a stop request while running holds the core in the next cycle.
    p_stop_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && stop_req) |=> (stop_hold && !core_clk_en));

    // R5: the idle stop state is left only on a wake pulse.
    p_idle_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hold && $past(stop_req) && !wake) |=> stop_hold);

    // R9: the clock enable excludes both hold outputs.
    p_gate_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_clk_en && (int_rst || stop_hold)) && !(int_rst && stop_hold));

    // R2: during the reset wait, ticks from other sources never release it.
    p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst && !tick_main16 && (tick_sub || tick_pin || src_sel != 2'b00))
        |=> int_rst);
endmodule

bind osw_seq osw_seq_chk #(
    .TOTAL ((int'(PRE_LO) + 1) * (int'(PRE_HI) + 1))
) u_osw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wake        (wake),
    .src_sel     (src_sel),
    .tick_main16 (tick_main16),
    .tick_sub    (tick_sub),
    .tick_pin    (tick_pin),
    .int_rst     (int_rst),
    .stop_hold   (stop_hold),
    .core_clk_en (core_clk_en)
);

// File: tb/tb_osw_seq.sv
// Bench for osw_seq: a vector table for the stop-path sources, then
// directed tests for the reset wait, restart and ignored requests.
module tb_osw_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_TICKS = 256 * 8;
    localparam int WDOG       = 150000;

    // Vector: {src_sel[1:0], good source[1:0], foreign source[1:0]}
    // Source codes: 0 = main/16, 1 = sub, 2 = pin.
    localparam logic [5:0] VEC [4] = '{
        {2'b00, 2'd0, 2'd1},
        {2'b01, 2'd1, 2'd0},
        {2'b10, 2'd2, 2'd0},
        {2'b11, 2'd2, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       tick_main16 = 1'b0;
    logic       tick_sub = 1'b0;
    logic       tick_pin = 1'b0;
    logic       int_rst, stop_hold, core_clk_en;

    int errors = 0;
    int checks = 0;

    localparam logic [2:0] O_RST  = 3'b100;
    localparam logic [2:0] O_STOP = 3'b010;
    localparam logic [2:0] O_RUN  = 3'b001;

    always #(CLK_PERIOD / 2) clk = ~clk;

    osw_seq dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
        .src_sel(src_sel), .tick_main16(tick_main16), .tick_sub(tick_sub),
        .tick_pin(tick_pin), .int_rst(int_rst), .stop_hold(stop_hold),
        .core_clk_en(core_clk_en)
    );

    // Compare {int_rst, stop_hold, core_clk_en} with the expected triple.
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {int_rst, stop_hold, core_clk_en};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Send n one-cycle pulses on the chosen source (0 main, 1 sub, 2 pin).
    task automatic pulse(input int src, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_main16 = (src == 0);
            tick_sub    = (src == 1);
            tick_pin    = (src == 2);
            @(negedge clk);
            tick_main16 = 1'b0;
            tick_sub    = 1'b0;
            tick_pin    = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic one_cycle_stop();
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: outputs=%b expected=done", {int_rst, stop_hold, core_clk_en});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: state during reset and right after it.
        repeat (3) @(negedge clk);
        chk("R1 in reset", O_RST);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", O_RST);

        // R2, R10: foreign sources, src_sel and stop_req during the reset wait.
        src_sel = 2'b01;
        pulse(1, 20);
        pulse(2, 20);
        one_cycle_stop();
        chk("R10 stop_req in reset wait", O_RST);
        pulse(0, WAIT_TICKS - 1);
        chk("R2/R3 held after 2047 main ticks", O_RST);
        pulse(0, 1);
        chk("R3 released after 2048 ticks", O_RUN);
        chk("R4/R10 running state", O_RUN);

        // R5, R6, R7: stop path for each source setting in the table.
        for (int v = 0; v < 4; v++) begin
            src_sel = VEC[v][5:4];
            one_cycle_stop();
            chk("R5 stop entered", O_STOP);
            pulse(int'(VEC[v][3:2]), 7);
            chk("R5 idle before wake", O_STOP);
            @(negedge clk);
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            pulse(int'(VEC[v][1:0]), 9);
            chk("R6 foreign source ignored", O_STOP);
            pulse(int'(VEC[v][3:2]), WAIT_TICKS - 1);
            chk("R7 held after 2047 selected ticks", O_STOP);
            pulse(int'(VEC[v][3:2]), 1);
            chk("R7 released after 2048 selected ticks", O_RUN);
        end

        // R8: reset part way through the reset wait restarts the count.
        do_reset();
        chk("R8 back in reset wait", O_RST);
        pulse(0, 1500);
        do_reset();
        pulse(0, WAIT_TICKS - 1);
        chk("R8 full wait after restart", O_RST);
        pulse(0, 1);
        chk("R8 release after restart", O_RUN);

        // R8: reset during a stop countdown enters the reset wait afresh.
        src_sel = 2'b00;
        one_cycle_stop();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        pulse(0, 1000);
        do_reset();
        chk("R8 reset from stop wait", O_RST);
        pulse(0, WAIT_TICKS - 1);
        chk("R8 full reset wait from stop", O_RST);
        pulse(0, 1);
        chk("R8/R4 release", O_RUN);

        // R9: exclusivity seen at the ports in the stop-idle state.
        one_cycle_stop();
        chk("R9 stop holds clock off", O_STOP);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule